// File: doc/BRIEF.md
# Interrupt Source Bank with Delivery Retry

The block holds per-source state for a bank of interrupt sources and turns source events into delivery requests toward an interrupt presenter. Each source keeps a target server number, an 8-bit priority, a level (asserted) flag, a masked-pending latch and a resend flag. A rising edge on a source's level input queues it for delivery. A delivery attempt first clears the source's resend flag. A masked source (priority 0xFF) is latched as masked-pending instead of being sent. An unmasked source raises a request carrying its index, server and priority, and the request is held until the presenter answers.

A refused delivery flags the source for resend and raises a one-cycle post so that the target presenter can mark this bank in its resend map. If the presenter reports that its need-resend flag is already clear while the post is up, the attempt is repeated at once. An accepted delivery that displaced a non-IPI source sends that displaced source back through the full sequence. A scan command walks the bank in ascending index order and redelivers every flagged source. An end-of-interrupt for a source that is still asserted redelivers it.

Top module: `irq_source_bank`

## Requirements
- R1: After reset no request, no resend post and no scan-done pulse is active, and every source priority is 0xFF (masked).
- R2: A rising edge on `src_level[i]` produces a request with `dlv_idx`=i and the source's configured server and priority. The request and its fields stay stable until `pres_ack`.
- R3: Priority 0xFF means masked, and lower values are more favoured. An attempt on a masked source makes no request and latches masked-pending instead. A later write of a non-masked priority to that source clears the latch and starts exactly one delivery.
- R4: A refusal (`pres_ack`=1, `pres_accept`=0) sets the source's resend flag. In the next cycle it raises `rsnd_post` for exactly one cycle, with `rsnd_server` equal to the request's server.
- R5: If `pres_need_resend` is low during the `rsnd_post` cycle, the same source is attempted again at once. If it is high, no retry follows.
- R6: A `scan_start` pulse visits sources 0 to NSRC-1 in ascending order and redelivers each one whose resend flag is set. `scan_done` pulses for one cycle after the last delivery. Because each attempt clears the flag, a source whose last attempt was accepted is not sent again.
- R7: An end-of-interrupt (`eoi_valid`) with `eoi_ipi`=0 for a source whose level is still high redelivers it. An end-of-interrupt with `eoi_ipi`=1, or for a source whose level is low, makes no request.
- R8: An acceptance with `disp_valid`=1 and `disp_ipi`=0 redelivers source `disp_idx`. With `disp_ipi`=1 nothing further is requested.
- R9: A flagged source that is masked when it is resent is latched as masked-pending and not dropped. Unmasking it later delivers it.
- R10: Sources queued in the same cycle are served in ascending index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write server and priority of one source |
| cfg_idx | input | IDX_W | Source written |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | PRIO_W | New priority (all ones = masked) |
| src_level | input | NSRC | Level of each source; a rising edge queues delivery |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_ipi | input | 1 | End-of-interrupt refers to an IPI (ignored) |
| eoi_idx | input | IDX_W | Source the end-of-interrupt refers to |
| scan_start | input | 1 | Start a resend scan of the bank |
| scan_done | output | 1 | One-cycle pulse when the scan has finished |
| dlv_req | output | 1 | Delivery request to the presenter |
| dlv_idx | output | IDX_W | Source being delivered |
| dlv_server | output | SRV_W | Target server of the request |
| dlv_prio | output | PRIO_W | Priority of the request |
| pres_ack | input | 1 | Presenter answers the request this cycle |
| pres_accept | input | 1 | Answer is acceptance (else refusal) |
| pres_need_resend | input | 1 | Presenter's current need-resend flag |
| disp_valid | input | 1 | Acceptance displaced a pending interrupt |
| disp_ipi | input | 1 | Displaced interrupt was an IPI |
| disp_idx | input | IDX_W | Displaced source index |
| rsnd_post | output | 1 | Set this bank's bit in the target's resend map |
| rsnd_server | output | SRV_W | Server whose resend map is to be marked |

## Verification
The bench builds the block with its defaults: 16 sources, 4-bit server numbers and 8-bit priorities. With these values the highest index (15) and index 0 are both reachable, and a full scan over every source is short. Priority 0xFF masks a source and 0x00 is the most favoured level, so both ends of the priority range are exercised. The bench uses a presenter model driven by tasks. That model can refuse with the need-resend flag either high or low, and it can report displaced sources both as ordinary sources and as IPIs. This brings the immediate retry, the scan redelivery and the displacement paths within reach.

// File: rtl/irq_source_bank.sv
module irq_source_bank #(
  parameter int NSRC   = 16,
  parameter int SRV_W  = 4,
  parameter int PRIO_W = 8,
  localparam int IDX_W = $clog2(NSRC),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [NSRC-1:0]   src_level,
  input  logic              eoi_valid,
  input  logic              eoi_ipi,
  input  logic [IDX_W-1:0]  eoi_idx,
  input  logic              scan_start,
  output logic              scan_done,
  output logic              dlv_req,
  output logic [IDX_W-1:0]  dlv_idx,
  output logic [SRV_W-1:0]  dlv_server,
  output logic [PRIO_W-1:0] dlv_prio,
  input  logic              pres_ack,
  input  logic              pres_accept,
  input  logic              pres_need_resend,
  input  logic              disp_valid,
  input  logic              disp_ipi,
  input  logic [IDX_W-1:0]  disp_idx,
  output logic              rsnd_post,
  output logic [SRV_W-1:0]  rsnd_server
);

  localparam logic [PRIO_W-1:0] MASKED = '1;
  localparam logic [NSRC-1:0]   ONE    = NSRC'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_REQ, ST_POST} st_t;

  st_t               st_q;
  logic [SRV_W-1:0]  srv_q  [NSRC];
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [NSRC-1:0]   lvl_q, mpend_q, rsnd_q, pend_q;
  logic [IDX_W-1:0]  cur_idx;
  logic [SRV_W-1:0]  cur_srv;
  logic [PRIO_W-1:0] cur_prio;
  logic              scan_busy;
  logic [PTR_W-1:0]  scan_ptr;
  logic [IDX_W-1:0]  pick;
  logic              pick_any;

  always_comb begin
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend_q[i]) pick = IDX_W'(i);
  end
  assign pick_any = |pend_q;

  wire start_masked = (st_q == ST_START) && (prio_q[cur_idx] == MASKED);
  wire refused      = (st_q == ST_REQ) && pres_ack && !pres_accept;
  wire unmask_hit   = cfg_we && (cfg_prio != MASKED) && mpend_q[cfg_idx];

  wire [NSRC-1:0] eoi_set    = (eoi_valid && !eoi_ipi && lvl_q[eoi_idx]) ? (ONE << eoi_idx) : '0;
  wire [NSRC-1:0] unmask_set = unmask_hit ? (ONE << cfg_idx) : '0;
  wire [NSRC-1:0] pend_set   = (src_level & ~lvl_q) | eoi_set | unmask_set;
  wire [NSRC-1:0] pend_clr   = (st_q == ST_IDLE && pick_any) ? (ONE << pick) : '0;
  wire [NSRC-1:0] cur_bit    = ONE << cur_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        srv_q[i]  <= '0;
        prio_q[i] <= MASKED;
      end
    end else if (cfg_we) begin
      srv_q[cfg_idx]  <= cfg_server;
      prio_q[cfg_idx] <= cfg_prio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      pend_q  <= '0;
      mpend_q <= '0;
      rsnd_q  <= '0;
    end else begin
      lvl_q   <= src_level;
      pend_q  <= (pend_q & ~pend_clr) | pend_set;
      mpend_q <= (mpend_q & ~unmask_set) | (start_masked ? cur_bit : '0);
      rsnd_q  <= (rsnd_q & ~((st_q == ST_START) ? cur_bit : '0)) | (refused ? cur_bit : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cur_idx   <= '0;
      cur_srv   <= '0;
      cur_prio  <= '0;
      scan_busy <= 1'b0;
      scan_ptr  <= '0;
      scan_done <= 1'b0;
    end else begin
      scan_done <= 1'b0;
      if (scan_start && !scan_busy) begin
        scan_busy <= 1'b1;
        scan_ptr  <= '0;
      end
      case (st_q)
        ST_IDLE: begin
          if (pick_any) begin
            cur_idx <= pick;
            st_q    <= ST_START;
          end else if (scan_busy) begin
            if (scan_ptr == PTR_W'(NSRC)) begin
              scan_busy <= 1'b0;
              scan_done <= 1'b1;
            end else begin
              scan_ptr <= scan_ptr + 1'b1;
              if (rsnd_q[scan_ptr[IDX_W-1:0]]) begin
                cur_idx <= scan_ptr[IDX_W-1:0];
                st_q    <= ST_START;
              end
            end
          end
        end
        ST_START: begin
          if (start_masked) begin
            st_q <= ST_IDLE;
          end else begin
            cur_srv  <= srv_q[cur_idx];
            cur_prio <= prio_q[cur_idx];
            st_q     <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (pres_ack) begin
            if (!pres_accept) begin
              st_q <= ST_POST;
            end else if (disp_valid && !disp_ipi) begin
              cur_idx <= disp_idx;
              st_q    <= ST_START;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= pres_need_resend ? ST_IDLE : ST_START;
      endcase
    end
  end

  assign dlv_req     = (st_q == ST_REQ);
  assign dlv_idx     = cur_idx;
  assign dlv_server  = cur_srv;
  assign dlv_prio    = cur_prio;
  assign rsnd_post   = (st_q == ST_POST);
  assign rsnd_server = cur_srv;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_req && !pres_ack |=> dlv_req && $stable(dlv_idx) && $stable(dlv_prio) && $stable(dlv_server)); // R2
  AST_NO_MASKED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_req |-> dlv_prio != MASKED); // R3
  AST_REFUSE_POST: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_req && pres_ack && !pres_accept |=> rsnd_post && $stable(dlv_server)); // R4
  AST_RETRY_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsnd_post && !pres_need_resend |=> !rsnd_post && !dlv_req && $stable(dlv_idx)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done); // R6

endmodule

// File: tb/irq_source_bank_bench.sv
module irq_source_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [3:0]  cfg_server = '0;
  logic [7:0]  cfg_prio = '0;
  logic [15:0] src_level = '0;
  logic        eoi_valid = 1'b0, eoi_ipi = 1'b0;
  logic [3:0]  eoi_idx = '0;
  logic        scan_start = 1'b0;
  logic        scan_done, dlv_req, rsnd_post;
  logic [3:0]  dlv_idx, dlv_server, rsnd_server;
  logic [7:0]  dlv_prio;
  logic        pres_ack = 1'b0, pres_accept = 1'b0, pres_need_resend = 1'b1;
  logic        disp_valid = 1'b0, disp_ipi = 1'b0;
  logic [3:0]  disp_idx = '0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irq_source_bank u_irq_source_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .src_level(src_level), .eoi_valid(eoi_valid), .eoi_ipi(eoi_ipi),
    .eoi_idx(eoi_idx), .scan_start(scan_start), .scan_done(scan_done), .dlv_req(dlv_req),
    .dlv_idx(dlv_idx), .dlv_server(dlv_server), .dlv_prio(dlv_prio), .pres_ack(pres_ack),
    .pres_accept(pres_accept), .pres_need_resend(pres_need_resend), .disp_valid(disp_valid),
    .disp_ipi(disp_ipi), .disp_idx(disp_idx), .rsnd_post(rsnd_post), .rsnd_server(rsnd_server)
  );

  // {index, server, priority}
  localparam logic [15:0] VEC [4] = '{16'h1310, 16'h7940, 16'hC200, 16'hFFFE};

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] i, input logic [3:0] s, input logic [7:0] p);
    cfg_we = 1'b1; cfg_idx = i; cfg_server = s; cfg_prio = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_req(input logic [3:0] i, input logic [3:0] s, input logic [7:0] p, input string tag);
    int n = 0;
    while (!dlv_req && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(dlv_req, {tag, " request"}, int'(dlv_req), 1);
    chk(dlv_idx == i, {tag, " index"}, int'(dlv_idx), int'(i));
    chk(dlv_server == s, {tag, " server"}, int'(dlv_server), int'(s));
    chk(dlv_prio == p, {tag, " priority"}, int'(dlv_prio), int'(p));
  endtask

  task automatic answer(input logic acc, input logic dv, input logic di, input logic [3:0] dx);
    pres_ack = 1'b1; pres_accept = acc; disp_valid = dv; disp_ipi = di; disp_idx = dx;
    @(negedge clk);
    pres_ack = 1'b0; disp_valid = 1'b0; disp_ipi = 1'b0;
  endtask

  task automatic expect_none(input int n, input string tag);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (dlv_req) seen = 1;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!scan_done && !dlv_req && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(scan_done && !dlv_req, tag, int'(scan_done), 1);
    @(negedge clk);
  endtask

  task automatic pulse_scan;
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
  endtask

  task automatic pulse_eoi(input logic ipi, input logic [3:0] i);
    eoi_valid = 1'b1; eoi_ipi = ipi; eoi_idx = i;
    @(negedge clk);
    eoi_valid = 1'b0; eoi_ipi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!dlv_req && !rsnd_post && !scan_done, "R1 idle after reset", int'(dlv_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dlv_req && !rsnd_post && !scan_done, "R1 idle after release", int'(rsnd_post), 0);

    // R2 vector walk
    foreach (VEC[v]) begin
      cfg(VEC[v][15:12], VEC[v][11:8], VEC[v][7:0]);
      src_level[VEC[v][15:12]] = 1'b1;
      @(negedge clk);
      wait_req(VEC[v][15:12], VEC[v][11:8], VEC[v][7:0], "R2 table");
      repeat (2) @(negedge clk);
      chk(dlv_req && dlv_idx == VEC[v][15:12], "R2 held until answer", int'(dlv_idx), int'(VEC[v][15:12]));
      answer(1'b1, 1'b0, 1'b0, 4'd0);
      src_level[VEC[v][15:12]] = 1'b0;
      @(negedge clk);
    end

    // R3 masked source latched, delivered on unmask, once
    src_level[4] = 1'b1;
    expect_none(8, "R3 masked source not sent");
    cfg(4'd4, 4'd6, 8'h20);
    wait_req(4'd4, 4'd6, 8'h20, "R3 unmask delivers");
    answer(1'b1, 1'b0, 1'b0, 4'd0);
    cfg(4'd4, 4'd6, 8'h21);
    expect_none(8, "R3 latch cleared after delivery");
    src_level[4] = 1'b0;

    // R4 refusal with need-resend high: post, no retry
    cfg(4'd6, 4'd5, 8'h30);
    src_level[6] = 1'b1;
    wait_req(4'd6, 4'd5, 8'h30, "R4 first attempt");
    answer(1'b0, 1'b0, 1'b0, 4'd0);
    chk(rsnd_post && rsnd_server == 4'd5, "R4 resend post", int'(rsnd_server), 5);
    @(negedge clk);
    chk(!rsnd_post, "R4 post is one cycle", int'(rsnd_post), 0);
    expect_none(6, "R5 no retry when need-resend high");
    cfg(4'd11, 4'd1, 8'h60);
    src_level[11] = 1'b1;
    wait_req(4'd11, 4'd1, 8'h60, "R4 second source");
    answer(1'b0, 1'b0, 1'b0, 4'd0);
    chk(rsnd_post && rsnd_server == 4'd1, "R4 resend post server", int'(rsnd_server), 1);

    // R5 refusal with need-resend low: immediate retry
    cfg(4'd8, 4'd10, 8'h50);
    src_level[8] = 1'b1;
    pres_need_resend = 1'b0;
    wait_req(4'd8, 4'd10, 8'h50, "R5 first attempt");
    answer(1'b0, 1'b0, 1'b0, 4'd0);
    chk(rsnd_post, "R5 post before retry", int'(rsnd_post), 1);
    @(negedge clk);
    pres_need_resend = 1'b1;
    wait_req(4'd8, 4'd10, 8'h50, "R5 retry");
    answer(1'b1, 1'b0, 1'b0, 4'd0);
    src_level[6] = 1'b0; src_level[8] = 1'b0; src_level[11] = 1'b0;

    // R6 scan redelivers 6 then 11, skips 8
    pulse_scan();
    wait_req(4'd6, 4'd5, 8'h30, "R6 scan first");
    answer(1'b1, 1'b0, 1'b0, 4'd0);
    wait_req(4'd11, 4'd1, 8'h60, "R6 scan second");
    answer(1'b1, 1'b0, 1'b0, 4'd0);
    wait_done("R6 scan done");
    pulse_scan();
    wait_done("R6 empty scan done without request");

    // R9 flagged source masked at resend time is latched
    cfg(4'd13, 4'd3, 8'h70);
    src_level[13] = 1'b1;
    wait_req(4'd13, 4'd3, 8'h70, "R9 attempt");
    answer(1'b0, 1'b0, 1'b0, 4'd0);
    src_level[13] = 1'b0;
    cfg(4'd13, 4'd3, 8'hFF);
    pulse_scan();
    wait_done("R9 masked resend makes no request");
    cfg(4'd13, 4'd3, 8'h35);
    wait_req(4'd13, 4'd3, 8'h35, "R9 unmask delivers latched resend");
    answer(1'b1, 1'b0, 1'b0, 4'd0);

    // R7 end-of-interrupt recheck
    cfg(4'd2, 4'd4, 8'h22);
    src_level[2] = 1'b1;
    wait_req(4'd2, 4'd4, 8'h22, "R7 initial");
    answer(1'b1, 1'b0, 1'b0, 4'd0);
    pulse_eoi(1'b0, 4'd2);
    wait_req(4'd2, 4'd4, 8'h22, "R7 still asserted redelivers");
    answer(1'b1, 1'b0, 1'b0, 4'd0);
    pulse_eoi(1'b1, 4'd2);
    expect_none(6, "R7 IPI end-of-interrupt ignored");
    src_level[2] = 1'b0;
    @(negedge clk);
    pulse_eoi(1'b0, 4'd2);
    expect_none(6, "R7 deasserted end-of-interrupt ignored");

    // R8 displacement
    cfg(4'd9, 4'd8, 8'h45);
    cfg(4'd5, 4'd7, 8'h15);
    src_level[5] = 1'b1;
    wait_req(4'd5, 4'd7, 8'h15, "R8 displacing source");
    answer(1'b1, 1'b1, 1'b0, 4'd9);
    wait_req(4'd9, 4'd8, 8'h45, "R8 displaced redelivered");
    answer(1'b1, 1'b0, 1'b0, 4'd0);
    cfg(4'd10, 4'd2, 8'h11);
    src_level[10] = 1'b1;
    wait_req(4'd10, 4'd2, 8'h11, "R8 source displacing IPI");
    answer(1'b1, 1'b1, 1'b1, 4'd9);
    expect_none(6, "R8 displaced IPI not redelivered");

    // R10 ascending service order
    cfg(4'd14, 4'd1, 8'h05);
    cfg(4'd0, 4'd12, 8'h06);
    src_level[14] = 1'b1; src_level[0] = 1'b1;
    @(negedge clk);
    wait_req(4'd0, 4'd12, 8'h06, "R10 lowest index first");
    answer(1'b1, 1'b0, 1'b0, 4'd0);
    wait_req(4'd14, 4'd1, 8'h05, "R10 next index");
    answer(1'b1, 1'b0, 1'b0, 4'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule